// File: doc/BRIEF.md
# Serial Interrupt Host Controller

This block is the host end of a one-wire, open-drain interrupt bus. The wire idles high through an outside pull-up, and any agent may pull it low. Each bus cycle follows a fixed sequence:

- The host opens the cycle with a long low pulse.
- The wire is left floating for one clock.
- A fixed number of three-clock frames follow, one per interrupt source.
- The host closes the cycle with a short low pulse, which is the Stop frame.

In the first clock of every frame, the peripheral that owns that frame can pull the wire low. The host samples the wire at the end of that clock and turns the sample into a level on a per-source request vector.

The width of the Stop pulse sets the bus mode for the next cycle, and a configuration input selects it.

- **Three-clock Stop:** the host starts every following cycle on its own.
- **Two-clock Stop:** the host waits until a device pulls the wire low for a clock. The host then holds the wire low for the rest of the opening pulse, which is one clock shorter than its own opening pulse.

The frames fall into three groups:

- **Low frames (legacy):** a high sample means the source is requesting.
- **Upper frames:** these carry active-low sources, where a low sample means a request.
- **Ignored frames:** a few slots are never taken from the wire at all.

The pad is modelled by a drive-low enable output and a sampled-level input.

Top module: `sirq_host`

## Requirements
- R1: After the opening pulse, the host floats the wire for exactly one clock. Then 21 frames of three clocks each follow. Slot k is sampled at the end of the first clock of frame k, that is, in clock 9+3k counted from the first clock of an 8-clock opening pulse. At most one request output changes per clock.
- R2: After reset, and after every three-clock Stop, the host's own opening pulse keeps `line_oe` at 1 for exactly 8 consecutive clocks.
- R3: When a device pulls the wire low for one idle clock, the host asserts `line_oe` on the next clock and keeps it at 1 for exactly 7 clocks.
- R4: The Stop pulse keeps `line_oe` at 1 for 3 clocks when `cfg_continuous` is 1 as the Stop begins, and for 2 clocks when it is 0.
- R5: After a three-clock Stop, `line_oe` is 0 for exactly 2 clocks (one float clock and one idle clock), and then the next opening pulse begins.
- R6: After a two-clock Stop, the host keeps `line_oe` at 0 for as long as the wire stays high.
- R7: For slots 0 to 15, except the ignored ones, the request bit takes the sampled wire level (1 = high = requesting).
- R8: For slots 16 to 20, the request bit is the inverse of the sampled level (low = requesting).
- R9: Slots 0, 8 and 13 are ignored. Their request bits stay 0 whatever the wire carries in their frames.
- R10: While reset is low, `line_oe` is 0 and every request bit is 0. The first cycle after reset uses the host-started mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_continuous | input | 1 | Stop width select: 1 gives a three-clock Stop and host-started cycles, 0 gives a two-clock Stop and device-started cycles |
| line_in | input | 1 | Level sampled from the wire |
| line_oe | output | 1 | 1 pulls the wire low, 0 floats it |
| irq_req | output | 21 | Decoded request level per slot |

## Verification
The bench builds the block with its default parameters: 21 slots, 16 legacy slots, an 8-clock opening pulse, and slots 0, 8 and 13 ignored. That size makes it practical to run a full walking-one and walking-zero sweep across every slot, plus all-ones, all-zeros and alternating patterns. The Stop width alternates from cycle to cycle, so both opening-pulse lengths, both gap behaviours and both sample polarities are reached many times. A slot decoded one frame early or late, a wrong polarity, or a leak into an ignored slot shows up as a specific slot mismatch.

// File: rtl/sirq_pkg.sv
// Shared types for the serial interrupt host.
// Assumes: one sequencer state per bus phase; slot polarity depends only on slot index.
package sirq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_TURN,
        ST_FRAME,
        ST_STOP,
        ST_REC
    } sirq_state_e;

    // Slots at or above the legacy count carry active-low requests.
    function automatic logic slot_is_active_low(input int slot, input int num_legacy);
        return slot >= num_legacy;
    endfunction

endpackage

// File: rtl/sirq_seq.sv
// Cycle sequencer: issues opening and Stop pulses, walks the three-clock
// frames, and raises a sample strobe with the slot index.
// Assumes: line_in is already synchronous to clk; the Stop width is taken
// from cfg_continuous as the Stop begins.
module sirq_seq
    import sirq_pkg::*;
#(
    parameter int NUM_FRAMES = 21,
    parameter int START_LEN  = 8,
    parameter int IDX_W      = 5,
    parameter int CNT_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_continuous,
    input  logic             line_in,
    output logic             line_oe,
    output logic             smp_en,
    output logic [IDX_W-1:0] smp_idx
);

    sirq_state_e      state;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] idx;
    logic [1:0]       phase;
    logic             bus_cont;
    logic             stop_cont;

    // Advance the bus phase sequence one clock at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            idx       <= '0;
            phase     <= '0;
            bus_cont  <= 1'b1;
            stop_cont <= 1'b1;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (bus_cont) begin
                        state <= ST_START;
                        cnt   <= CNT_W'(START_LEN - 1);
                    end else if (!line_in) begin
                        state <= ST_START;
                        cnt   <= CNT_W'(START_LEN - 2);
                    end
                end
                ST_START: begin
                    if (cnt == '0) begin
                        state <= ST_TURN;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_TURN: begin
                    state <= ST_FRAME;
                    idx   <= '0;
                    phase <= '0;
                end
                ST_FRAME: begin
                    if (phase == 2'd2) begin
                        phase <= '0;
                        if (idx == IDX_W'(NUM_FRAMES - 1)) begin
                            state     <= ST_STOP;
                            cnt       <= cfg_continuous ? CNT_W'(2) : CNT_W'(1);
                            stop_cont <= cfg_continuous;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end else begin
                        phase <= phase + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (cnt == '0) begin
                        state    <= ST_REC;
                        bus_cont <= stop_cont;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Drive the wire low only during the host's own pulses.
    always_comb begin
        line_oe = (state == ST_START) || (state == ST_STOP);
        smp_en  = (state == ST_FRAME) && (phase == 2'd0);
        smp_idx = idx;
    end

endmodule

// File: rtl/sirq_decode.sv
// Slot decoder: one request flop per slot, loaded from the wire when that
// slot's sample strobe fires, with per-slot polarity and ignore mask.
// Assumes: at most one strobe per clock; ignored slots stay at 0.
module sirq_decode
    import sirq_pkg::*;
#(
    parameter int                    NUM_FRAMES  = 21,
    parameter int                    NUM_LEGACY  = 16,
    parameter int                    IDX_W       = 5,
    parameter logic [NUM_FRAMES-1:0] IGNORE_MASK = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  smp_en,
    input  logic [IDX_W-1:0]      smp_idx,
    input  logic                  line_in,
    output logic [NUM_FRAMES-1:0] irq_req
);

    for (genvar k = 0; k < NUM_FRAMES; k++) begin : g_slot
        if (IGNORE_MASK[k]) begin : g_ign
            assign irq_req[k] = 1'b0;
        end else begin : g_live
            localparam logic ACT_LOW = slot_is_active_low(k, NUM_LEGACY);
            // Capture this slot's level in its sample clock.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    irq_req[k] <= 1'b0;
                end else if (smp_en && smp_idx == IDX_W'(k)) begin
                    irq_req[k] <= line_in ^ ACT_LOW;
                end
            end
        end
    end

endmodule

// File: rtl/sirq_host.sv
// Serial interrupt host top: sequencer plus slot decoder.
// Assumes: open-drain pad outside; line_in is the resolved wire level.
module sirq_host #(
    parameter int                    NUM_FRAMES  = 21,
    parameter int                    NUM_LEGACY  = 16,
    parameter int                    START_LEN   = 8,
    parameter logic [NUM_FRAMES-1:0] IGNORE_MASK = 21'h002101
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_continuous,
    input  logic                  line_in,
    output logic                  line_oe,
    output logic [NUM_FRAMES-1:0] irq_req
);

    localparam int IDX_W = (NUM_FRAMES > 2) ? $clog2(NUM_FRAMES) : 1;
    localparam int CNT_W = (START_LEN > 4) ? $clog2(START_LEN) : 2;

    logic             smp_en;
    logic [IDX_W-1:0] smp_idx;

    sirq_seq #(
        .NUM_FRAMES (NUM_FRAMES),
        .START_LEN  (START_LEN),
        .IDX_W      (IDX_W),
        .CNT_W      (CNT_W)
    ) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_continuous (cfg_continuous),
        .line_in        (line_in),
        .line_oe        (line_oe),
        .smp_en         (smp_en),
        .smp_idx        (smp_idx)
    );

    sirq_decode #(
        .NUM_FRAMES  (NUM_FRAMES),
        .NUM_LEGACY  (NUM_LEGACY),
        .IDX_W       (IDX_W),
        .IGNORE_MASK (IGNORE_MASK)
    ) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_en  (smp_en),
        .smp_idx (smp_idx),
        .line_in (line_in),
        .irq_req (irq_req)
    );

endmodule

// File: rtl/sirq_host_chk.sv
// Checker for sirq_host: pulse lengths, gaps and request updates at the ports.
// Assumes: attached by bind; observes only top-level ports.
module sirq_host_chk #(
    parameter int                    NUM_FRAMES  = 21,
    parameter logic [NUM_FRAMES-1:0] IGNORE_MASK = '0
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  line_oe,
    input logic                  line_in,
    input logic [NUM_FRAMES-1:0] irq_req
);

    logic [7:0] run;
    logic [7:0] last_run;

    // Measure each drive pulse and remember the most recent length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run      <= '0;
            last_run <= '0;
        end else if (line_oe) begin
            run <= run + 1'b1;
        end else begin
            run <= '0;
            if (run != '0) last_run <= run;
        end
    end

    // R2 R3 R4: every drive pulse has one of the legal lengths.
    a_r4_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_oe && run != '0) |-> (run == 8'd2 || run == 8'd3 || run == 8'd7 || run == 8'd8));

    // R9: ignored slots never carry a request.
    a_r9_ignored_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req & IGNORE_MASK) == '0);

    // R1: one slot is sampled per clock at most.
    a_r1_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(irq_req) |-> $countones(irq_req ^ $past(irq_req)) == 1);

    // R6: after a two-clock Stop, a new pulse needs a device pull first.
    a_r6_device_start: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(line_oe) && last_run == 8'd2) |-> !$past(line_in));

    // R5: after a three-clock Stop, the next pulse follows two low clocks.
    a_r5_restart_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(line_oe) && last_run == 8'd3) |-> ($past(line_oe, 3) && !$past(line_oe, 2)));

endmodule

bind sirq_host sirq_host_chk #(
    .NUM_FRAMES  (NUM_FRAMES),
    .IGNORE_MASK (IGNORE_MASK)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_oe (line_oe),
    .line_in (line_in),
    .irq_req (irq_req)
);

// File: tb/sirq_host_bench.sv
`timescale 1ns/1ps
module sirq_host_bench;

    localparam int NF   = 21;
    localparam int NL   = 16;
    localparam int NCYC = 46;
    localparam logic [NF-1:0] IGN = 21'h002101;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg = 1'b1;
    logic          line_oe;
    logic [NF-1:0] irq_req;
    logic          dev_low = 1'b0;
    logic          quiet_pull = 1'b0;
    logic [NF-1:0] dev_req = '0;
    wire           line_in = !(line_oe || dev_low);

    int n_chk = 0;
    int n_fail = 0;
    int cyc_cnt = 0;
    bit done = 0;

    sirq_host u_sirq_host (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_continuous (cfg),
        .line_in        (line_in),
        .line_oe        (line_oe),
        .irq_req        (irq_req)
    );

    initial forever #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [NF-1:0] pat(input int i);
        if (i == 0) return '0;
        if (i == 1) return '1;
        if (i == 2) return 21'h155555;
        if (i == 3) return 21'h0AAAAA;
        if (i < 25) return NF'(1) << (i - 4);
        if (i < 46) return ~(NF'(1) << (i - 25));
        return '0;
    endfunction

    // Device model and pulse monitor, evaluated mid-cycle.
    initial begin
        int run = 0;
        int pos = -1;
        int gap = 0;
        bit gap_on = 0;
        int exp_start = 8;
        int exp_stop;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                run = 0; pos = -1; gap_on = 0; exp_start = 8; dev_low = 1'b0;
            end else begin
                dev_low = quiet_pull;
                if (line_oe) begin
                    if (run == 0 && gap_on) begin
                        if (exp_start == 8) chk(gap == 2, "R5 gap", gap, 2);
                        gap_on = 0;
                    end
                    run++;
                end else begin
                    if (run >= 4) begin
                        chk(run == exp_start, exp_start == 8 ? "R2 start" : "R3 start", run, exp_start);
                        pos = 0;
                    end else if (run >= 1) begin
                        exp_stop = cfg ? 3 : 2;
                        chk(run == exp_stop, "R4 stop", run, exp_stop);
                        exp_start = cfg ? 8 : 7;
                        pos = -1; gap = 1; gap_on = 1;
                        cyc_cnt++;
                    end else begin
                        if (gap_on) gap++;
                        if (pos >= 0) begin
                            pos++;
                            if ((pos - 1) % 3 == 0 && (pos - 1) / 3 < NF) begin
                                int k;
                                k = (pos - 1) / 3;
                                dev_low = (k < NL) ? !dev_req[k] : dev_req[k];
                            end
                        end
                    end
                    run = 0;
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc_cnt, NCYC);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        bit prev_cfg;
        dev_req = pat(0);
        cfg = 1'b1;
        repeat (4) @(negedge clk);
        chk(line_oe == 1'b0, "R10 oe", int'(line_oe), 0);
        chk(irq_req == '0, "R10 req", int'(irq_req), 0);
        rst_n = 1'b1;
        for (int i = 0; i < NCYC; i++) begin
            wait (cyc_cnt == i + 1);
            for (int k = 0; k < NF; k++) begin
                logic e;
                e = IGN[k] ? 1'b0 : dev_req[k];
                chk(irq_req[k] == e, IGN[k] ? "R9 ignored" : (k < NL ? "R7 legacy" : "R8 active-low"),
                    int'(irq_req[k]), int'(e));
            end
            prev_cfg = cfg;
            dev_req = pat(i + 1);
            cfg = ((i + 1) % 2 == 0);
            if (!prev_cfg && i + 1 < NCYC) begin
                for (int w = 0; w < 10; w++) begin
                    @(negedge clk); #1;
                    chk(line_oe == 1'b0, "R6 idle", int'(line_oe), 0);
                end
                quiet_pull = 1'b1;
                @(negedge clk); #1;
                quiet_pull = 1'b0;
            end
        end
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule